// File: doc/BRIEF.md
# Field-synchronous shadow register bank

This block holds the control registers of a video-processing pipeline: gamma curves, colour scales, brightness, caption bytes and copy-management fields. Each register is a pair, a shadow copy written by the host and an active copy that feeds the pipeline. A change made in the middle of a picture would tear it, so the active copies can be held back. With buffering on, they take the shadow contents once per field, on the last blanking line before active video.

There are two independent domains, each with its own buffering enable. The high-definition domain holds two gamma curves and the copy-generation bytes. The standard-definition domain holds two gamma curves, the luma and two chroma scales, brightness, the caption bytes and a 6-bit copy-protection field. With a domain's enable clear, host writes reach its active copies on the next clock. The field timer counts line strobes from the field-start strobe to find the commit line. A commit is skipped if active video is already asserted on that line.

Top module: `fieldsync_regbank`

## Requirements
- R1: On reset, both copies take their defaults. Gamma point k (0..9) of either curve is 16*(k+1). The standard-definition scale registers at offsets 20, 21 and 22 are 0x80. Every other register is 0x00.
- R2: `wr_addr[5]` selects the domain (0 = high-definition, 1 = standard-definition) and `wr_addr[4:0]` is the register offset. High-definition offsets are gamma A 0..9, gamma B 10..19 and copy-generation 20..22. Standard-definition offsets are gamma A 0..9, gamma B 10..19, Y scale 20, Cr scale 21, Cb scale 22, brightness 23, caption 24..27 and copy-protect 28. Register at offset i drives bits [8i+7:8i] of its domain's active bus.
- R3: With a domain's enable low, a write shows on that domain's active bus on the clock after the write.
- R4: With a domain's enable high, the active bus of that domain does not change except on a commit.
- R5: A commit happens on the `line_start` pulse that begins line VBLANK_LINES-1, counting the line begun by `field_start` as line 0. Active copies then take the shadow contents, visible one clock later. There is at most one commit per field.
- R6: A write in the same cycle as a commit lands only in the shadow copy and is committed at the next field.
- R7: The two domains are independent: one domain's enable and writes never change the other domain's bus.
- R8: The copy-protect register keeps only its low 6 bits; bits 7:6 of its active byte are always 0.
- R9: Writes to offsets with no register (high-definition 23..31, standard-definition 29..31) change nothing.
- R10: Clearing a domain's enable while its shadow holds uncommitted data moves that data to the active bus on the next clock.
- R11: If `active_video` is high on the commit line's `line_start` pulse, no commit happens for that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 6 | Domain select bit and register offset |
| wr_data | input | 8 | Host write data |
| field_start | input | 1 | One-cycle pulse at the start of a field (line 0) |
| line_start | input | 1 | One-cycle pulse at the start of each further line |
| active_video | input | 1 | High during active picture lines |
| hd_buf_en | input | 1 | Field buffering enable, high-definition domain |
| sd_buf_en | input | 1 | Field buffering enable, standard-definition domain |
| hd_active | output | 184 | Active high-definition registers, 23 bytes |
| sd_active | output | 232 | Active standard-definition registers, 29 bytes |

## Verification
Directed writes, each placed against the field timing, separate four cases. Some fall in mid-field with buffering on and must stay hidden. Some fall with buffering off and must appear at once. One lands on the commit line itself and must wait a whole field. One lands on unmapped offsets and must vanish. Toggling one domain's enable while the other domain is written tells domain leakage apart from correct independence. An active-video level on the commit line checks that the commit is suppressed. A random phase then mixes writes to all 64 addresses, rare enable flips and regular field timing. It is compared every cycle with a reference model, which catches off-by-one errors in the line count and in the byte lanes.

// File: rtl/fsrb_pkg.sv
package fsrb_pkg;

    localparam int DATA_W       = 8;
    localparam int OFF_W        = 5;
    localparam int ADDR_W       = OFF_W + 1;
    localparam int GAMMA_PTS    = 10;
    localparam int HD_CGMS_REGS = 3;
    localparam int SD_CC_REGS   = 4;

    localparam int GAMMA_REGS   = 2 * GAMMA_PTS;
    localparam int HD_NREG      = GAMMA_REGS + HD_CGMS_REGS;
    localparam int SD_YSCALE    = GAMMA_REGS;
    localparam int SD_CRSCALE   = GAMMA_REGS + 1;
    localparam int SD_CBSCALE   = GAMMA_REGS + 2;
    localparam int SD_BRIGHT    = GAMMA_REGS + 3;
    localparam int SD_CC_BASE   = GAMMA_REGS + 4;
    localparam int SD_CPROT     = SD_CC_BASE + SD_CC_REGS;
    localparam int SD_NREG      = SD_CPROT + 1;
    localparam int HD_BUS_W     = HD_NREG * DATA_W;
    localparam int SD_BUS_W     = SD_NREG * DATA_W;
    localparam int CPROT_BITS   = 6;

    typedef enum logic {
        DOM_HD = 1'b0,
        DOM_SD = 1'b1
    } dom_e;

    typedef struct packed {
        logic               valid;
        dom_e               dom;
        logic [OFF_W-1:0]   off;
        logic [DATA_W-1:0]  data;
    } host_wr_t;

    function automatic logic [DATA_W-1:0] reg_default(dom_e d, int idx);
        if (idx < GAMMA_REGS)
            return DATA_W'(((idx % GAMMA_PTS) + 1) * 16);
        if (d == DOM_SD && idx >= SD_YSCALE && idx <= SD_CBSCALE)
            return DATA_W'(8'h80);
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] reg_mask(dom_e d, int idx);
        if (d == DOM_SD && idx == SD_CPROT)
            return DATA_W'((1 << CPROT_BITS) - 1);
        return '1;
    endfunction

endpackage

// File: rtl/fsrb_host_decode.sv
module fsrb_host_decode
    import fsrb_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output host_wr_t          req,
    output logic              hd_hit,
    output logic              sd_hit
);
    localparam logic [OFF_W-1:0] HD_LAST = OFF_W'(HD_NREG - 1);
    localparam logic [OFF_W-1:0] SD_LAST = OFF_W'(SD_NREG - 1);

    always_comb begin
        req.valid = wr_en;
        req.dom   = dom_e'(wr_addr[ADDR_W-1]);
        req.off   = wr_addr[OFF_W-1:0];
        req.data  = wr_data;
        hd_hit    = req.valid && (req.dom == DOM_HD) && (req.off <= HD_LAST);
        sd_hit    = req.valid && (req.dom == DOM_SD) && (req.off <= SD_LAST);
    end
endmodule

// File: rtl/fsrb_field_timer.sv
module fsrb_field_timer #(
    parameter int VBLANK_LINES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic field_start,
    input  logic line_start,
    input  logic active_video,
    output logic commit
);
    localparam int             LW   = (VBLANK_LINES > 2) ? $clog2(VBLANK_LINES) : 1;
    localparam logic [LW-1:0]  LAST = LW'(VBLANK_LINES - 1);
    localparam logic [LW-1:0]  PRE  = LW'(VBLANK_LINES - 2);

    logic [LW-1:0] line_idx;

    // The counter rests saturated at LAST, so no commit fires before the first field.
    always_ff @(posedge clk) begin
        if (rst)
            line_idx <= LAST;
        else if (field_start)
            line_idx <= '0;
        else if (line_start && line_idx != LAST)
            line_idx <= line_idx + 1'b1;
    end

    assign commit = line_start && !field_start && !active_video && (line_idx == PRE);
endmodule

// File: rtl/fsrb_domain.sv
module fsrb_domain
    import fsrb_pkg::*;
#(
    parameter dom_e DOM  = DOM_HD,
    parameter int   NREG = HD_NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    buf_en,
    input  logic                    commit,
    input  logic                    wr_hit,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [NREG*DATA_W-1:0]  active_flat,
    output logic [NREG*DATA_W-1:0]  shadow_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] DEF  = reg_default(DOM, i);
        localparam logic [DATA_W-1:0] MASK = reg_mask(DOM, i);

        logic [DATA_W-1:0] sh_q, sh_d, ac_q, ac_d;

        always_comb begin
            sh_d = sh_q;
            if (wr_hit && wr_off == OFF_W'(i))
                sh_d = wr_data & MASK;
        end

        // Buffered: take the old shadow on commit. Unbuffered: follow the shadow input.
        always_comb begin
            if (buf_en)
                ac_d = commit ? sh_q : ac_q;
            else
                ac_d = sh_d;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= DEF;
                ac_q <= DEF;
            end else begin
                sh_q <= sh_d;
                ac_q <= ac_d;
            end
        end

        assign active_flat[i*DATA_W +: DATA_W] = ac_q;
        assign shadow_flat[i*DATA_W +: DATA_W] = sh_q;
    end
endmodule

// File: rtl/fieldsync_regbank.sv
module fieldsync_regbank
    import fsrb_pkg::*;
#(
    parameter int VBLANK_LINES = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                field_start,
    input  logic                line_start,
    input  logic                active_video,
    input  logic                hd_buf_en,
    input  logic                sd_buf_en,
    output logic [HD_BUS_W-1:0] hd_active,
    output logic [SD_BUS_W-1:0] sd_active
);
    host_wr_t            req;
    logic                hd_hit, sd_hit;
    logic                commit;
    logic [HD_BUS_W-1:0] hd_shadow;
    logic [SD_BUS_W-1:0] sd_shadow;

    fsrb_host_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .req     (req),
        .hd_hit  (hd_hit),
        .sd_hit  (sd_hit)
    );

    fsrb_field_timer #(.VBLANK_LINES(VBLANK_LINES)) u_tmr (
        .clk          (clk),
        .rst          (rst),
        .field_start  (field_start),
        .line_start   (line_start),
        .active_video (active_video),
        .commit       (commit)
    );

    fsrb_domain #(.DOM(DOM_HD), .NREG(HD_NREG)) u_hd (
        .clk         (clk),
        .rst         (rst),
        .buf_en      (hd_buf_en),
        .commit      (commit),
        .wr_hit      (hd_hit),
        .wr_off      (req.off),
        .wr_data     (req.data),
        .active_flat (hd_active),
        .shadow_flat (hd_shadow)
    );

    fsrb_domain #(.DOM(DOM_SD), .NREG(SD_NREG)) u_sd (
        .clk         (clk),
        .rst         (rst),
        .buf_en      (sd_buf_en),
        .commit      (commit),
        .wr_hit      (sd_hit),
        .wr_off      (req.off),
        .wr_data     (req.data),
        .active_flat (sd_active),
        .shadow_flat (sd_shadow)
    );
endmodule

// File: rtl/fieldsync_regbank_chk.sv
module fieldsync_regbank_chk
    import fsrb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                field_start,
    input logic                commit,
    input logic                hd_buf_en,
    input logic                sd_buf_en,
    input logic [HD_BUS_W-1:0] hd_active,
    input logic [SD_BUS_W-1:0] sd_active,
    input logic [HD_BUS_W-1:0] hd_shadow,
    input logic [SD_BUS_W-1:0] sd_shadow
);
    logic done_this_field;

    always_ff @(posedge clk) begin
        if (rst || field_start)
            done_this_field <= 1'b0;
        else if (commit)
            done_this_field <= 1'b1;
    end

    AST_ONE_COMMIT_PER_FIELD: assert property (@(posedge clk) disable iff (rst)
        commit |-> !done_this_field) else $error("second commit in one field"); // R5

    AST_HD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hd_buf_en && $past(hd_buf_en) && !$past(commit)) |-> $stable(hd_active)) else $error("hd moved outside commit"); // R4

    AST_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sd_buf_en && $past(sd_buf_en) && !$past(commit)) |-> $stable(sd_active)) else $error("sd moved outside commit"); // R4

    AST_HD_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(commit && hd_buf_en) |-> (hd_active == $past(hd_shadow))) else $error("hd commit value"); // R5

    AST_SD_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(commit && sd_buf_en) |-> (sd_active == $past(sd_shadow))) else $error("sd commit value"); // R5

    AST_HD_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        $past(!hd_buf_en) |-> (hd_active == hd_shadow)) else $error("hd unbuffered lag"); // R3

    AST_SD_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        $past(!sd_buf_en) |-> (sd_active == sd_shadow)) else $error("sd unbuffered lag"); // R3

    AST_CPROT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        sd_active[SD_CPROT*DATA_W+CPROT_BITS +: DATA_W-CPROT_BITS] == '0) else $error("cprot upper bits"); // R8
endmodule

bind fieldsync_regbank fieldsync_regbank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .field_start (field_start),
    .commit      (commit),
    .hd_buf_en   (hd_buf_en),
    .sd_buf_en   (sd_buf_en),
    .hd_active   (hd_active),
    .sd_active   (sd_active),
    .hd_shadow   (hd_shadow),
    .sd_shadow   (sd_shadow)
);

// File: tb/test_fieldsync_regbank.sv
`timescale 1ns/1ps
module test_fieldsync_regbank;
    localparam int VBL  = 20;
    localparam int HD_N = 23;
    localparam int SD_N = 29;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic field_start = 1'b0, line_start = 1'b0, active_video = 1'b0;
    logic hd_buf_en = 1'b0, sd_buf_en = 1'b0;
    logic [HD_N*8-1:0] hd_active;
    logic [SD_N*8-1:0] sd_active;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [7:0] m_hd_sh[HD_N], m_hd_ac[HD_N], m_sd_sh[SD_N], m_sd_ac[SD_N];
    int m_line;

    always #2.5 clk = ~clk;

    fieldsync_regbank #(.VBLANK_LINES(VBL)) i_fieldsync_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .field_start(field_start), .line_start(line_start), .active_video(active_video),
        .hd_buf_en(hd_buf_en), .sd_buf_en(sd_buf_en),
        .hd_active(hd_active), .sd_active(sd_active)
    );

    // Defaults and masks as stated in R1 and R8.
    function automatic logic [7:0] exp_default(bit sd, int i);
        if (i < 20) return 8'(16 * ((i % 10) + 1));
        if (sd && i >= 20 && i <= 22) return 8'h80;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_mask(bit sd, int i);
        return (sd && i == 28) ? 8'h3F : 8'hFF;
    endfunction

    function automatic logic [7:0] hd_byte(int i);
        return hd_active[i*8 +: 8];
    endfunction

    function automatic logic [7:0] sd_byte(int i);
        return sd_active[i*8 +: 8];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < HD_N; i++) begin
            m_hd_sh[i] = exp_default(1'b0, i);
            m_hd_ac[i] = exp_default(1'b0, i);
        end
        for (int i = 0; i < SD_N; i++) begin
            m_sd_sh[i] = exp_default(1'b1, i);
            m_sd_ac[i] = exp_default(1'b1, i);
        end
        m_line = VBL - 1;
    endtask

    task automatic model_tick(logic we, logic [5:0] a, logic [7:0] d,
                              logic fs, logic ls, logic av, logic ehd, logic esd);
        logic cm;
        int off;
        cm = ls && !fs && !av && (m_line == VBL - 2);
        if (fs) m_line = 0;
        else if (ls && m_line < VBL - 1) m_line++;
        off = int'(a[4:0]);
        for (int i = 0; i < HD_N; i++) begin
            logic [7:0] nsh;
            nsh = m_hd_sh[i];
            if (we && !a[5] && off == i) nsh = d;
            if (!ehd) m_hd_ac[i] = nsh;
            else if (cm) m_hd_ac[i] = m_hd_sh[i];
            m_hd_sh[i] = nsh;
        end
        for (int i = 0; i < SD_N; i++) begin
            logic [7:0] nsh;
            nsh = m_sd_sh[i];
            if (we && a[5] && off == i) nsh = d & exp_mask(1'b1, i);
            if (!esd) m_sd_ac[i] = nsh;
            else if (cm) m_sd_ac[i] = m_sd_sh[i];
            m_sd_sh[i] = nsh;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(logic we, logic [5:0] a, logic [7:0] d, logic fs, logic ls, logic av);
        wr_en = we; wr_addr = a; wr_data = d;
        field_start = fs; line_start = ls; active_video = av;
        @(posedge clk);
        model_tick(we, a, d, fs, ls, av, hd_buf_en, sd_buf_en);
        @(negedge clk);
        wr_en = 1'b0; field_start = 1'b0; line_start = 1'b0; active_video = 1'b0;
    endtask

    task automatic hwrite(logic [5:0] a, logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic field_begin();
        step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic line();
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic check_byte(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        bit bad;
        bad = 1'b0;
        n_checks++;
        for (int i = 0; i < HD_N && !bad; i++)
            if (hd_byte(i) !== m_hd_ac[i]) begin
                bad = 1'b1;
                $display("FAIL %s hd byte %0d actual %02h expected %02h", tag, i, hd_byte(i), m_hd_ac[i]);
            end
        for (int i = 0; i < SD_N && !bad; i++)
            if (sd_byte(i) !== m_sd_ac[i]) begin
                bad = 1'b1;
                $display("FAIL %s sd byte %0d actual %02h expected %02h", tag, i, sd_byte(i), m_sd_ac[i]);
            end
        if (bad) n_errors++;
    endtask

    task automatic reach_commit_line();
        field_begin();
        for (int k = 0; k < VBL - 2; k++) line();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset defaults
        check_byte("R1 hd gamma A pt0", hd_byte(0), 8'd16);
        check_byte("R1 hd gamma B pt9", hd_byte(19), 8'd160);
        check_byte("R1 hd cgms", hd_byte(21), 8'h00);
        check_byte("R1 sd Y scale", sd_byte(20), 8'h80);
        check_byte("R1 sd Cb scale", sd_byte(22), 8'h80);
        check_byte("R1 sd brightness", sd_byte(23), 8'h00);
        check_all("R1 all");

        // R3: unbuffered write visible next clock
        hwrite(6'h03, 8'hA5);
        check_byte("R3 hd off3", hd_byte(3), 8'hA5);

        // R2: domain select and byte lane
        hwrite(6'h20 | 6'd21, 8'h3C);
        check_byte("R2 sd off21", sd_byte(21), 8'h3C);
        check_byte("R2 hd off21 untouched", hd_byte(21), 8'h00);

        // R8: copy-protect keeps 6 bits
        hwrite(6'h20 | 6'd28, 8'hFF);
        check_byte("R8 sd cprot", sd_byte(28), 8'h3F);

        // R9: unmapped offsets
        hwrite(6'd23, 8'h99);
        hwrite(6'h20 | 6'd30, 8'h77);
        check_all("R9 unmapped");

        // R4 / R5: buffered hd write held until commit line
        hd_buf_en = 1'b1;
        hwrite(6'd20, 8'h5A);
        check_byte("R4 held after write", hd_byte(20), 8'h00);
        reach_commit_line();
        check_byte("R4 held before commit line", hd_byte(20), 8'h00);
        line();
        check_byte("R5 committed", hd_byte(20), 8'h5A);
        hwrite(6'd20, 8'h66);
        repeat (3) line();
        check_byte("R5 once per field", hd_byte(20), 8'h5A);

        // R6: write coinciding with commit
        reach_commit_line();
        step(1'b1, 6'd20, 8'h77, 1'b0, 1'b1, 1'b0);
        check_byte("R6 commit takes older shadow", hd_byte(20), 8'h66);
        reach_commit_line();
        line();
        check_byte("R6 committed next field", hd_byte(20), 8'h77);

        // R7: domains independent
        hwrite(6'h20, 8'h12);
        check_byte("R7 sd unbuffered while hd buffered", sd_byte(0), 8'h12);
        hwrite(6'h00, 8'h34);
        check_byte("R7 hd still held", hd_byte(0), 8'd16);

        // R10: clearing enable releases pending shadow
        sd_buf_en = 1'b1;
        hd_buf_en = 1'b0;
        idle();
        check_byte("R10 hd released", hd_byte(0), 8'h34);
        check_byte("R7 sd unaffected", sd_byte(0), 8'h12);

        // R11: active video on commit line suppresses commit
        hd_buf_en = 1'b1;
        hwrite(6'h01, 8'hC3);
        reach_commit_line();
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b1);
        check_byte("R11 no commit", hd_byte(1), 8'd32);
        check_all("R11 all");

        // R2 random phase against model with regular field timing
        for (int c = 0; c < 3000; c++) begin
            int pos;
            logic fs, ls, av, we;
            pos = c % ((VBL + 6) * 4);
            fs = (pos == 0);
            ls = (pos != 0) && (pos % 4 == 0);
            av = (pos / 4) >= VBL;
            we = ($urandom % 3) == 0;
            if (($urandom % 64) == 0) hd_buf_en = ~hd_buf_en;
            if (($urandom % 64) == 0) sd_buf_en = ~sd_buf_en;
            step(we, 6'($urandom % 64), 8'($urandom), fs, ls, av);
            check_all("R2 random");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule